// File: doc/BRIEF.md
# Linear Sensor Readout Sequencer

This block is the digital timing core of a two-section linear photodiode array. Each section has 768 pixel stages, so the array has 1536 pixels. A rising start pulse on a section's serial input is taken in at a clock edge and puts a single token into that section's stage chain. The token moves one stage per clock and selects each pixel in turn. While the token is inside the chain, the section's output enable is high. This enable stands in for the analog output leaving high impedance. The selected pixel is also given as a global binary index from 0 to 1535.

The same start event issues a one-clock hold strobe, which parks the sampling capacitors. It also opens an integrator-reset window that lasts a fixed 18 clocks. When the token reaches a section's last stage, the section raises its serial-out pulse. In chained mode, section 0's serial-out pulse starts section 1, so one start pulse reads out all 1536 pixels in order. In independent mode, each section runs from its own start input.

A start that arrives before the previous readout has drained, plus a programmable charge-transfer gap, is discarded. Such a start raises a sticky per-section error flag, which stays set until it is cleared.

Top module: `lrs_top`

## Requirements
- R1: A start is accepted at the first clock edge where the section's serial input is high after being low. After accepting edge number k, counting that edge as 1, section s reports index s*768 + k - 1 for k from 1 to 768.
- R2: The section's select vector has exactly one bit set, bit k-1, while the output enable is high. The output enable is high only after edges 1 to 768 of the section's own run; otherwise the select vector is zero.
- R3: The serial-out pulse of a section is high only after edge 768 of its run, which is the edge of its last pixel. It is low again after edge 769.
- R4: The hold strobe is high for exactly one cycle, after the accepting edge.
- R5: The integrator-reset window is high after edges 1 through 18 of a run and low after edge 19.
- R6: In chained mode (mode input = 1), section 1 starts at the edge after section 0's serial-out pulse rises, so it reports indices 768 to 1535 after edges 769 to 1536. Section 1's own serial input is ignored and raises no error. Section 1's hold strobe and reset window follow section 0's start.
- R7: In independent mode (mode input = 0), each section starts only from its own serial input. Sections started at different edges keep their own timing.
- R8: A start seen before edge C*768 + 1 + GAP is ignored and sets that section's error flag. Here C is 1 in independent mode and 2 for section 0 in chained mode, and GAP defaults to 4. A start at exactly that edge is accepted without error.
- R9: A high error-clear input at an edge clears all error flags, unless the same edge also sets a flag; setting wins.
- R10: A low asynchronous reset immediately drives output enables, select vectors, serial-out pulses, hold strobes, reset windows and error flags low. The reset is released two clocks after the reset input rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chain_mode_i | input | 1 | 1 = sections chained, 0 = independent |
| si_i | input | 2 | Serial start input per section |
| err_clr_i | input | 1 | Clears the sticky error flags |
| hold_o | output | 2 | Hold strobe per section |
| irst_o | output | 2 | Integrator-reset window per section |
| sel_o | output | 2x768 | One-hot pixel select per section |
| oe_o | output | 2 | Output enable per section |
| idx_o | output | 2x11 | Global index of the selected pixel per section |
| so_o | output | 2 | Serial-out pulse per section |
| err_o | output | 2 | Sticky early-start error per section |

## Verification
Two events can fall in the same cycle, and both are provoked on purpose.

The first pair is an early start and an error-clear. An illegal start is driven in the same cycle that the clear input is pulsed. The bench then expects the error flag to remain set, because setting wins over clearing.

The second pair is the drain of one section and the take-in of the next start. In chained mode, section 0's last pixel and serial-out pulse arrive at edge 768. The bench checks that section 1's first pixel (index 768) appears at the very next edge, with no gap and no overlap. A start placed exactly at the first legal edge is accepted cleanly. A start one edge earlier is judged an error.

// File: rtl/lrs_pkg.sv
package lrs_pkg;
  localparam int unsigned DEF_PIX     = 768;
  localparam int unsigned DEF_SEC     = 2;
  localparam int unsigned DEF_RST_WIN = 18;
  localparam int unsigned DEF_GAP     = 4;

  typedef enum logic {
    MODE_INDEP = 1'b0,
    MODE_CHAIN = 1'b1
  } chain_mode_e;
endpackage

// File: rtl/lrs_token_chain.sv
module lrs_token_chain #(
  parameter int unsigned PIX   = 768,
  parameter int unsigned BASE  = 0,
  parameter int unsigned IDX_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  output logic [PIX-1:0]   sel_o,
  output logic             oe_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             last_o
);
  localparam int unsigned PW = (PIX > 1) ? $clog2(PIX) : 1;
  localparam logic [PW-1:0] POS_END = PW'(PIX - 1);

  logic [PIX-1:0] stg_q, stg_d;
  logic [PW-1:0]  pos_q, pos_d;
  logic           act_q, act_d;

  // Next-state: token shift and the position counter kept in step with it
  always_comb begin
    stg_d = {stg_q[PIX-2:0], start_i};
    pos_d = pos_q;
    act_d = act_q;
    if (start_i) begin
      pos_d = '0;
      act_d = 1'b1;
    end else if (act_q) begin
      if (pos_q == POS_END) begin
        act_d = 1'b0;
      end else begin
        pos_d = pos_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
      pos_q <= '0;
      act_q <= 1'b0;
    end else begin
      stg_q <= stg_d;
      pos_q <= pos_d;
      act_q <= act_d;
    end
  end

  assign sel_o  = stg_q;
  assign oe_o   = act_q;
  assign idx_o  = IDX_W'(BASE) + IDX_W'(pos_q);
  assign last_o = stg_q[PIX-1];

  p_sel_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stg_q));
  p_sel_at_pos_r2: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> stg_q[pos_q]);
  p_idle_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !act_q |-> (stg_q == '0));
  p_last_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stg_q[PIX-1] && !start_i) |=> !stg_q[PIX-1]);
endmodule

// File: rtl/lrs_integ_ctrl.sv
module lrs_integ_ctrl #(
  parameter int unsigned RST_WIN = 18
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic hold_o,
  output logic irst_o
);
  localparam int unsigned CW = $clog2(RST_WIN + 1);

  logic [CW-1:0] win_q, win_d;
  logic          hold_q, hold_d;

  always_comb begin
    hold_d = start_i;
    if (start_i) begin
      win_d = CW'(RST_WIN);
    end else if (win_q != '0) begin
      win_d = win_q - 1'b1;
    end else begin
      win_d = win_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= '0;
      hold_q <= 1'b0;
    end else begin
      win_q  <= win_d;
      hold_q <= hold_d;
    end
  end

  assign hold_o = hold_q;
  assign irst_o = (win_q != '0);

  p_hold_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && !start_i) |=> !hold_q);
  p_hold_opens_win_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q |-> (win_q == CW'(RST_WIN)));
endmodule

// File: rtl/lrs_start_guard.sv
module lrs_start_guard #(
  parameter int unsigned GW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          si_i,
  input  logic [GW-1:0] limit_i,
  input  logic          err_clr_i,
  output logic          accept_o,
  output logic          err_o
);
  logic          si_q;
  logic [GW-1:0] busy_q, busy_d;
  logic          err_q, err_d;
  logic          req, early;

  always_comb begin
    req      = si_i && !si_q;
    early    = req && (busy_q != '0);
    accept_o = req && (busy_q == '0);
    if (accept_o) begin
      busy_d = limit_i;
    end else if (busy_q != '0) begin
      busy_d = busy_q - 1'b1;
    end else begin
      busy_d = busy_q;
    end
    if (early) begin
      err_d = 1'b1;
    end else if (err_clr_i) begin
      err_d = 1'b0;
    end else begin
      err_d = err_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      si_q   <= 1'b0;
      busy_q <= '0;
      err_q  <= 1'b0;
    end else begin
      si_q   <= si_i;
      busy_q <= busy_d;
      err_q  <= err_d;
    end
  end

  assign err_o = err_q;

  p_early_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (si_i && !si_q && busy_q != '0) |=> err_q);
  p_clear_drops_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr_i && !(si_i && !si_q && busy_q != '0)) |=> !err_q);
endmodule

// File: rtl/lrs_top.sv
module lrs_top #(
  parameter int unsigned PIX     = lrs_pkg::DEF_PIX,
  parameter int unsigned NSEC    = lrs_pkg::DEF_SEC,
  parameter int unsigned RST_WIN = lrs_pkg::DEF_RST_WIN,
  parameter int unsigned GAP     = lrs_pkg::DEF_GAP,
  localparam int unsigned IDX_W  = $clog2(PIX * NSEC)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        chain_mode_i,
  input  logic [NSEC-1:0]             si_i,
  input  logic                        err_clr_i,
  output logic [NSEC-1:0]             hold_o,
  output logic [NSEC-1:0]             irst_o,
  output logic [NSEC-1:0][PIX-1:0]    sel_o,
  output logic [NSEC-1:0]             oe_o,
  output logic [NSEC-1:0][IDX_W-1:0]  idx_o,
  output logic [NSEC-1:0]             so_o,
  output logic [NSEC-1:0]             err_o
);
  import lrs_pkg::*;

  localparam int unsigned GW = $clog2(PIX * NSEC + GAP + 1);
  localparam logic [GW-1:0] LIM_INDEP = GW'(PIX + GAP - 1);
  localparam logic [GW-1:0] LIM_CHAIN = GW'(NSEC * PIX + GAP - 1);

  chain_mode_e mode;
  logic [1:0]      rsync_q;
  logic            srst_n;
  logic [NSEC-1:0] accept, tok_start, integ_start, si_eff;

  assign mode = chain_mode_e'(chain_mode_i);

  // Asynchronous assert, synchronous two-flop release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync_q <= 2'b00;
    end else begin
      rsync_q <= {rsync_q[0], 1'b1};
    end
  end
  assign srst_n = rsync_q[1];

  for (genvar s = 0; s < NSEC; s++) begin : g_sec
    logic [GW-1:0] limit;

    if (s == 0) begin : g_head
      assign si_eff[s]    = si_i[s];
      assign limit        = (mode == MODE_CHAIN) ? LIM_CHAIN : LIM_INDEP;
      assign tok_start[s] = accept[s];
    end else begin : g_tail
      assign si_eff[s]    = (mode == MODE_CHAIN) ? 1'b0 : si_i[s];
      assign limit        = LIM_INDEP;
      assign tok_start[s] = (mode == MODE_CHAIN) ? so_o[s-1] : accept[s];

      p_chain_hand_r6: assert property (@(posedge clk) disable iff (!srst_n)
        (chain_mode_i && so_o[s-1]) |=> (oe_o[s] && idx_o[s] == IDX_W'(s * PIX)));
    end

    assign integ_start[s] = (mode == MODE_CHAIN) ? accept[0] : accept[s];

    lrs_start_guard #(.GW(GW)) u_guard (
      .clk       (clk),
      .rst_n     (srst_n),
      .si_i      (si_eff[s]),
      .limit_i   (limit),
      .err_clr_i (err_clr_i),
      .accept_o  (accept[s]),
      .err_o     (err_o[s])
    );

    lrs_integ_ctrl #(.RST_WIN(RST_WIN)) u_integ (
      .clk     (clk),
      .rst_n   (srst_n),
      .start_i (integ_start[s]),
      .hold_o  (hold_o[s]),
      .irst_o  (irst_o[s])
    );

    lrs_token_chain #(.PIX(PIX), .BASE(s * PIX), .IDX_W(IDX_W)) u_tok (
      .clk     (clk),
      .rst_n   (srst_n),
      .start_i (tok_start[s]),
      .sel_o   (sel_o[s]),
      .oe_o    (oe_o[s]),
      .idx_o   (idx_o[s]),
      .last_o  (so_o[s])
    );
  end

  p_reset_quiet_r10: assert property (@(posedge clk)
    !srst_n |-> (oe_o == '0 && so_o == '0 && err_o == '0));
endmodule

// File: tb/tb_lrs_top.sv
`timescale 1ns/1ps
module tb_lrs_top;
  localparam int PIX = 768;
  localparam int NS  = 2;
  localparam int WIN = 18;
  localparam int GAP = 4;
  localparam int IW  = $clog2(PIX * NS);

  logic                    clk = 1'b0;
  logic                    rst_n;
  logic                    chain_mode_i;
  logic [NS-1:0]           si_i;
  logic                    err_clr_i;
  logic [NS-1:0]           hold_o, irst_o, oe_o, so_o, err_o;
  logic [NS-1:0][PIX-1:0]  sel_o;
  logic [NS-1:0][IW-1:0]   idx_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  lrs_top #(.PIX(PIX), .NSEC(NS), .RST_WIN(WIN), .GAP(GAP)) dut (
    .clk(clk), .rst_n(rst_n), .chain_mode_i(chain_mode_i), .si_i(si_i),
    .err_clr_i(err_clr_i), .hold_o(hold_o), .irst_o(irst_o), .sel_o(sel_o),
    .oe_o(oe_o), .idx_o(idx_o), .so_o(so_o), .err_o(err_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  // Expected state of section s, k = edges since its own start (1 = accepting edge, <=0 = not started)
  task automatic expect_tok(input int s, input int k, input string req);
    bit e_oe;
    e_oe = (k >= 1 && k <= PIX);
    chk(oe_o[s] == e_oe, req, $sformatf("oe[%0d] k=%0d", s, k), oe_o[s], e_oe);
    chk(so_o[s] == (k == PIX), "R3", $sformatf("so[%0d] k=%0d", s, k), so_o[s], k == PIX);
    if (e_oe) begin
      chk(idx_o[s] == IW'(s * PIX + k - 1), "R1", $sformatf("idx[%0d] k=%0d", s, k),
          idx_o[s], s * PIX + k - 1);
      chk(sel_o[s][k-1] && $countones(sel_o[s]) == 1, "R2",
          $sformatf("sel[%0d] k=%0d", s, k), $countones(sel_o[s]), 1);
    end else begin
      chk(sel_o[s] == '0, "R2", $sformatf("sel idle[%0d] k=%0d", s, k), $countones(sel_o[s]), 0);
    end
  endtask

  task automatic expect_integ(input int s, input int k);
    chk(hold_o[s] == (k == 1), "R4", $sformatf("hold[%0d] k=%0d", s, k), hold_o[s], k == 1);
    chk(irst_o[s] == (k >= 1 && k <= WIN), "R5", $sformatf("irst[%0d] k=%0d", s, k),
        irst_o[s], k >= 1 && k <= WIN);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; si_i = '0; err_clr_i = 1'b0; chain_mode_i = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(3);
  endtask

  task automatic t_reset();
    do_reset();
    chk(oe_o == '0 && so_o == '0 && hold_o == '0 && irst_o == '0 && err_o == '0,
        "R10", "outputs after reset", {oe_o, so_o, hold_o, irst_o, err_o}, 0);
    chk(sel_o == '0, "R10", "select after reset", $countones(sel_o), 0);
    // mid-run asynchronous reset
    si_i[0] = 1'b1; tick(); si_i[0] = 1'b0; idle(10);
    chk(oe_o[0] == 1'b1, "R10", "run active before reset", oe_o[0], 1);
    #1 rst_n = 1'b0; #1;
    chk(oe_o == '0 && sel_o == '0 && irst_o == '0, "R10", "async clear mid-run",
        {oe_o, irst_o}, 0);
    @(negedge clk); rst_n = 1'b1; idle(3);
  endtask

  // R7: independent sections started at different edges
  task automatic t_indep();
    chain_mode_i = 1'b0;
    si_i[0] = 1'b1;
    for (int k = 1; k <= PIX + 8; k++) begin
      if (k == 5) si_i[1] = 1'b1;
      tick();
      si_i = '0;
      expect_tok(0, k, "R7");
      expect_integ(0, k);
      expect_tok(1, k - 4, "R7");
      expect_integ(1, k - 4);
      chk(err_o == '0, "R7", "no error", err_o, 0);
    end
    idle(2 * PIX);
  endtask

  // R6: chained readout; section 1's own input is ignored
  task automatic t_chain();
    chain_mode_i = 1'b1;
    si_i[0] = 1'b1;
    for (int k = 1; k <= 2 * PIX + 2; k++) begin
      if (k == 10 || k == 1000) si_i[1] = 1'b1;
      tick();
      si_i = '0;
      expect_tok(0, k, "R6");
      expect_integ(0, k);
      expect_integ(1, k);
      expect_tok(1, k - PIX, "R6");
    end
    chk(err_o == '0, "R6", "section 1 input raised no error", err_o, 0);
    idle(2 * PIX);
    chain_mode_i = 1'b0;
    idle(2);
  endtask

  // R8/R9: early start ignored, sticky flag, clear, and set-wins
  task automatic t_early();
    chain_mode_i = 1'b0;
    si_i[0] = 1'b1; tick(); si_i[0] = 1'b0;
    idle(98);
    si_i[0] = 1'b1; tick(); si_i[0] = 1'b0;   // edge 100
    chk(err_o[0] == 1'b1, "R8", "early start flags", err_o[0], 1);
    chk(idx_o[0] == IW'(99), "R8", "early start ignored idx", idx_o[0], 99);
    tick();
    chk(idx_o[0] == IW'(100), "R8", "run continues", idx_o[0], 100);
    idle(20);
    chk(err_o[0] == 1'b1, "R9", "flag stays set", err_o[0], 1);
    err_clr_i = 1'b1; tick(); err_clr_i = 1'b0;
    chk(err_o[0] == 1'b0, "R9", "clear drops flag", err_o[0], 0);
    si_i[0] = 1'b1; err_clr_i = 1'b1; tick(); si_i[0] = 1'b0; err_clr_i = 1'b0;
    chk(err_o[0] == 1'b1, "R9", "set wins over clear", err_o[0], 1);
    idle(2 * PIX);
    err_clr_i = 1'b1; tick(); err_clr_i = 1'b0;
    chk(err_o == '0, "R9", "cleared after run", err_o, 0);
  endtask

  // R8 boundary: one edge early is rejected, exact edge is accepted
  task automatic t_boundary();
    chain_mode_i = 1'b0;
    si_i[0] = 1'b1; tick(); si_i[0] = 1'b0;
    idle(PIX + GAP - 2);                          // now after edge PIX+GAP-1
    si_i[0] = 1'b1; tick(); si_i[0] = 1'b0;       // edge PIX+GAP
    chk(err_o[0] == 1'b1, "R8", "edge PIX+GAP rejected", err_o[0], 1);
    chk(oe_o[0] == 1'b0, "R8", "rejected start selects nothing", oe_o[0], 0);
    idle(2 * PIX);
    err_clr_i = 1'b1; tick(); err_clr_i = 1'b0;
    si_i[0] = 1'b1; tick(); si_i[0] = 1'b0;
    idle(PIX + GAP - 1);                          // now after edge PIX+GAP
    si_i[0] = 1'b1; tick(); si_i[0] = 1'b0;       // edge PIX+GAP+1
    chk(err_o[0] == 1'b0, "R8", "edge PIX+GAP+1 accepted", err_o[0], 0);
    chk(oe_o[0] == 1'b1 && idx_o[0] == '0, "R8", "new run at pixel 0", idx_o[0], 0);
    chk(hold_o[0] == 1'b1, "R4", "hold on accepted restart", hold_o[0], 1);
    idle(2 * PIX);
  endtask

  initial begin
    t_reset();
    t_indep();
    t_chain();
    t_early();
    t_boundary();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", fails, checks);
      $finish;
    end
  end
endmodule